// File: doc/BRIEF.md
# I2C Serial EEPROM Slave Engine

This block is the slave-side protocol engine for a 4096 x 8 byte-addressed memory on a two-wire bus. A fast system clock oversamples SCL and SDA. The engine detects START and STOP conditions and shifts in 8-bit words, most significant bit first. It matches the select byte against a fixed device code and three strap inputs. It answers on SDA through an open-drain enable: a high `sda_oe` pulls the line low.

The engine keeps a 12-bit current-address pointer and runs four flows: byte write, current-address read, random read (an address-setting write, then a repeated START) and sequential read. The storage array sits outside, behind a plain synchronous port. A read strobe returns data on the following cycle, and a write strobe commits in its own cycle. The port has no back-pressure: the array must accept every strobe, and it must return read data exactly one cycle after the strobe. Page buffering and the timed programming cycle belong to a separate block. Each accepted data byte is presented on the port as its own one-cycle write.

Top module: `eeprom_slave_engine`

## Requirements
- R1: A falling SDA while SCL is high is a START, and it begins a new select byte. A rising SDA while SCL is high is a STOP. A STOP releases SDA and makes the engine idle.
- R2: The select byte is code 1010 in bits 7:4, the strap value `dev_sel` in bits 3:1 (bit 3 = strap bit 2) and R/W in bit 0, where 1 means read. On a match, SDA is driven low for the whole ninth SCL clock.
- R3: If the code or the strap bits differ, the engine does not acknowledge. It then ignores every bit, and makes no memory access, until the next START.
- R4: After a select byte with R/W=0, two address bytes follow. The low 4 bits of the first byte form address bits 11:8, and its upper 4 bits are ignored. The second byte forms bits 7:0. Each of these bytes is acknowledged.
- R5: Each data byte after the address is acknowledged and written at the pointer. The pointer then steps within its 32-byte page: bits 4:0 wrap from 31 to 0, and bits 11:5 do not change.
- R6: A read without an address phase returns the byte at the last accessed address plus one. After reset the pointer is 0.
- R7: A write of two address bytes, then a repeated START with R/W=1, returns the byte at the loaded address.
- R8: During a read, a master ACK (0) on the ninth bit advances the pointer and sends the next byte. The pointer wraps from 4095 to 0.
- R9: After a master NACK (1), the engine keeps SDA released, even if clocks continue, until a START or STOP. The pointer still points one past the last byte that was sent.
- R10: Read data is sent MSB first. SDA output changes only while SCL is low.
- R11: Each accepted data byte produces exactly one single-cycle write strobe on the memory port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pin |
| sda_i | input | 1 | Serial data line as seen at the pin |
| sda_oe | output | 1 | When 1, the pad pulls SDA low |
| dev_sel | input | 3 | Strap value that the select byte's bits 3:1 must match |
| mem_addr | output | 12 | Memory port address |
| mem_we | output | 1 | Memory write strobe, one cycle |
| mem_wdata | output | 8 | Memory write data |
| mem_re | output | 1 | Memory read strobe; data is expected one cycle later |
| mem_rdata | input | 8 | Memory read data |

## Verification
The assertions assume that SCL stays in each level for at least four system clocks. They also assume that the master moves SDA only while SCL is low, except when it makes a START or a STOP. Under those conditions, a change of the output enable can only follow a detected falling edge, and a memory write can only follow the close of a byte. The bench holds each SCL level for eight clocks. It moves SDA four clocks into the low phase, and it samples the line in the middle of the high phase. Its memory model returns read data on the cycle after the strobe, so every input stays within those assumptions.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_ACK,
    ST_TX_PRE,
    ST_TX,
    ST_TX_ACK
  } eng_state_t;

  typedef enum logic [1:0] {
    PH_SELECT,
    PH_ADDR_HI,
    PH_ADDR_LO,
    PH_DATA
  } rx_phase_t;

  localparam logic [3:0] DEVICE_CODE = 4'b1010;
  localparam int BYTE_BITS = 8;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic scl_d;
  logic sda_d;

  // both lines go through the same depth, so their relative timing is kept
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_d    <= scl_pipe[STAGES-1];
      sda_d    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/eeprom_addr_ctr.sv
module eeprom_addr_ctr #(
  parameter int ADDR_W = 12,
  parameter int PAGE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              inc_page,
  input  logic              inc_full,
  output logic [ADDR_W-1:0] ptr
);
  logic [PAGE_W-1:0] page_lo_next;
  assign page_lo_next = ptr[PAGE_W-1:0] + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ptr <= '0;
    else if (load)     ptr <= load_val;
    else if (inc_page) ptr <= {ptr[ADDR_W-1:PAGE_W], page_lo_next};
    else if (inc_full) ptr <= ptr + 1'b1;
  end

  // R5: a step after a write keeps the page number
  assert_page_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_page && !load) |=> (ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W])));

  // R8: a step after a read from the top address lands on zero
  assert_array_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_full && !load && !inc_page && (&ptr)) |=> (ptr == '0));
endmodule

// File: rtl/eeprom_slave_engine.sv
module eeprom_slave_engine
  import eeprom_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int PAGE_W      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [2:0]        dev_sel,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [7:0]        mem_wdata,
  output logic              mem_re,
  input  logic [7:0]        mem_rdata
);
  localparam int HI_W = ADDR_W - BYTE_BITS;
  localparam logic [3:0] LAST_BIT = 4'(BYTE_BITS);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  eng_state_t state;
  rx_phase_t  phase;
  logic [3:0] bit_cnt;
  logic [7:0] rx_sh, tx_sh;
  logic [HI_W-1:0] hi_q;
  logic is_rd, rd_lat;
  logic ctr_load, ctr_inc_page, ctr_inc_full;
  logic [ADDR_W-1:0] ctr_val, ptr;
  logic sel_ok;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  eeprom_addr_ctr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .load(ctr_load), .load_val(ctr_val),
    .inc_page(ctr_inc_page), .inc_full(ctr_inc_full), .ptr(ptr)
  );

  assign sel_ok = (rx_sh[7:4] == DEVICE_CODE) && (rx_sh[3:1] == dev_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;      phase <= PH_SELECT;
      bit_cnt <= '0;         rx_sh <= '0;         tx_sh <= '0;
      hi_q <= '0;            is_rd <= 1'b0;       rd_lat <= 1'b0;
      sda_oe <= 1'b0;        mem_addr <= '0;      mem_we <= 1'b0;
      mem_wdata <= '0;       mem_re <= 1'b0;
      ctr_load <= 1'b0;      ctr_val <= '0;
      ctr_inc_page <= 1'b0;  ctr_inc_full <= 1'b0;
    end else begin
      mem_we <= 1'b0;        mem_re <= 1'b0;
      ctr_load <= 1'b0;      ctr_inc_page <= 1'b0;  ctr_inc_full <= 1'b0;
      rd_lat <= mem_re;
      if (rd_lat) tx_sh <= mem_rdata;
      if (stop_det) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else if (start_det) begin
        state   <= ST_RX;
        phase   <= PH_SELECT;
        bit_cnt <= '0;
        sda_oe  <= 1'b0;
      end else begin
        unique case (state)
          ST_RX: begin
            if (scl_rise && bit_cnt != LAST_BIT) begin
              rx_sh   <= {rx_sh[6:0], sda_s};
              bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall && bit_cnt == LAST_BIT) begin
              sda_oe <= 1'b1;
              state  <= ST_RX_ACK;
              is_rd  <= 1'b0;
              unique case (phase)
                PH_SELECT: begin
                  if (!sel_ok) begin
                    sda_oe <= 1'b0;
                    state  <= ST_IDLE;
                  end else if (rx_sh[0]) begin
                    is_rd        <= 1'b1;
                    mem_re       <= 1'b1;
                    mem_addr     <= ptr;
                    ctr_inc_full <= 1'b1;
                  end else begin
                    phase <= PH_ADDR_HI;
                  end
                end
                PH_ADDR_HI: begin
                  hi_q  <= rx_sh[HI_W-1:0];
                  phase <= PH_ADDR_LO;
                end
                PH_ADDR_LO: begin
                  ctr_load <= 1'b1;
                  ctr_val  <= {hi_q, rx_sh};
                  phase    <= PH_DATA;
                end
                PH_DATA: begin
                  mem_we       <= 1'b1;
                  mem_addr     <= ptr;
                  mem_wdata    <= rx_sh;
                  ctr_inc_page <= 1'b1;
                end
                default: ;
              endcase
            end
          end
          ST_RX_ACK: begin
            if (scl_fall) begin
              if (is_rd) begin
                state   <= ST_TX;
                sda_oe  <= ~tx_sh[7];
                bit_cnt <= 4'd1;
              end else begin
                state   <= ST_RX;
                sda_oe  <= 1'b0;
                bit_cnt <= '0;
              end
            end
          end
          ST_TX_PRE: begin
            if (scl_fall) begin
              state   <= ST_TX;
              sda_oe  <= ~tx_sh[7];
              bit_cnt <= 4'd1;
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bit_cnt != LAST_BIT) begin
                tx_sh   <= {tx_sh[6:0], 1'b0};
                sda_oe  <= ~tx_sh[6];
                bit_cnt <= bit_cnt + 4'd1;
              end else begin
                sda_oe <= 1'b0;
                state  <= ST_TX_ACK;
              end
            end
          end
          ST_TX_ACK: begin
            if (scl_rise) begin
              if (!sda_s) begin
                mem_re       <= 1'b1;
                mem_addr     <= ptr;
                ctr_inc_full <= 1'b1;
                state        <= ST_TX_PRE;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R2: the bit counter never passes one full word
  always_comb assert_bitcnt_range_R2: assert (bit_cnt <= LAST_BIT);

  // R10: the output enable only moves while the synchronized clock is low
  assert_oe_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);

  // R1: a detected stop leaves the line released
  assert_stop_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  // R11: a write strobe follows a detected falling clock edge
  assert_we_after_fall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(scl_fall));

  // R11: a write strobe lasts a single cycle
  assert_we_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);
endmodule

// File: tb/eeprom_slave_engine_test.sv
module eeprom_slave_engine_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] SEL_WR = {4'b1010, STRAP, 1'b0};
  localparam logic [7:0] SEL_RD = {4'b1010, STRAP, 1'b1};
  localparam int NVEC = 6;
  // {address[11:0], data[7:0]}
  localparam bit [19:0] VEC [NVEC] = '{
    20'h005_5A, 20'h7FF_C3, 20'h800_01, 20'hABC_FE, 20'hFFF_80, 20'h000_7E
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic [11:0] mem_addr;
  logic mem_we, mem_re;
  logic [7:0] mem_wdata, mem_rdata;
  logic sda_bus;
  logic [7:0] mem [4096];
  logic [7:0] ref_mem [4096];
  int n_chk = 0;
  int n_fail = 0;
  int we_cnt = 0;
  int we_long = 0;
  int bad_oe = 0;
  logic oe_prev = 1'b0;
  logic we_prev = 1'b0;
  bit done = 1'b0;

  assign sda_bus = sda_m & ~sda_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  eeprom_slave_engine uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .dev_sel(STRAP), .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_re(mem_re), .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    if (mem_re) mem_rdata <= mem[mem_addr];
    if (mem_we) we_cnt <= we_cnt + 1;
    if (mem_we && we_prev) we_long <= we_long + 1;
    if (rst_n && (sda_oe != oe_prev) && scl) bad_oe <= bad_oe + 1;
    we_prev <= mem_we;
    oe_prev <= sda_oe;
  end

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wt(4); scl = 1'b1; wt(8); sda_m = 1'b0; wt(8); scl = 1'b0; wt(4);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wt(4); scl = 1'b1; wt(8); sda_m = 1'b1; wt(8);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; wt(4); scl = 1'b1; wt(8); scl = 1'b0; wt(4);
  endtask

  task automatic recv_bit(output logic b);
    sda_m = 1'b1; wt(4); scl = 1'b1; wt(4); b = sda_bus; wt(4); scl = 1'b0; wt(4);
  endtask

  task automatic put_byte(input logic [7:0] d, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(b);
    acked = ~b;
  endtask

  task automatic get_byte(output logic [7:0] d, input logic master_ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b);
      d[i] = b;
    end
    send_bit(~master_ack);
  endtask

  task automatic set_addr(input logic [11:0] a);
    logic ak;
    bus_start();
    put_byte(SEL_WR, ak); check(ak, "R2 select ack", ak, 1);
    put_byte({4'hF, a[11:8]}, ak); check(ak, "R4 high address ack", ak, 1);
    put_byte(a[7:0], ak); check(ak, "R4 low address ack", ak, 1);
  endtask

  task automatic rand_read(input logic [11:0] a, output logic [7:0] d);
    logic ak;
    set_addr(a);
    bus_start();
    put_byte(SEL_RD, ak); check(ak, "R7 read select ack", ak, 1);
    get_byte(d, 1'b0);
    bus_stop();
  endtask

  task automatic cur_read(output logic [7:0] d);
    logic ak;
    bus_start();
    put_byte(SEL_RD, ak); check(ak, "R6 read select ack", ak, 1);
    get_byte(d, 1'b0);
    bus_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      finish_run();
    end
  end

  initial begin
    logic [7:0] d;
    logic ak;
    int w0;
    for (int i = 0; i < 4096; i++) begin
      mem[i] = 8'((i * 37 + 11) & 255);
      ref_mem[i] = mem[i];
    end
    wt(5);
    rst_n = 1'b1;
    wt(4);
    check(sda_oe == 1'b0, "R1 reset releases SDA", sda_oe, 0);
    check(mem_we == 1'b0, "R11 reset no write", mem_we, 0);

    // R6: pointer is zero after reset
    cur_read(d);
    check(d == ref_mem[0], "R6 current read after reset", d, ref_mem[0]);

    // table of single-byte writes, each read back through a random read
    for (int v = 0; v < NVEC; v++) begin
      logic [11:0] a;
      logic [7:0] wd;
      a = VEC[v][19:8];
      wd = VEC[v][7:0];
      w0 = we_cnt;
      set_addr(a);
      put_byte(wd, ak); check(ak, "R5 data ack", ak, 1);
      bus_stop();
      ref_mem[a] = wd;
      check(we_cnt - w0 == 1, "R11 one strobe per byte", we_cnt - w0, 1);
      rand_read(a, d);
      check(d == ref_mem[a], "R7 random read of written byte", d, ref_mem[a]);
    end

    // R3: wrong strap bits, then bits without a START, then wrong code
    w0 = we_cnt;
    bus_start();
    put_byte({4'b1010, 3'b000, 1'b0}, ak); check(!ak, "R3 strap mismatch nack", ak, 0);
    put_byte(SEL_WR, ak); check(!ak, "R3 ignored without start", ak, 0);
    put_byte(8'h55, ak); check(!ak, "R3 data ignored", ak, 0);
    bus_stop();
    bus_start();
    put_byte({4'b0010, STRAP, 1'b0}, ak); check(!ak, "R3 code mismatch nack", ak, 0);
    bus_stop();
    check(we_cnt == w0, "R3 no memory write", we_cnt - w0, 0);

    // R5: a four-byte write from 0x13E wraps inside its page
    set_addr(12'h13E);
    for (int k = 0; k < 4; k++) begin
      put_byte(8'hA0 + 8'(k), ak); check(ak, "R5 page data ack", ak, 1);
    end
    bus_stop();
    ref_mem[12'h13E] = 8'hA0; ref_mem[12'h13F] = 8'hA1;
    ref_mem[12'h120] = 8'hA2; ref_mem[12'h121] = 8'hA3;
    // R6: last write landed at 0x121
    cur_read(d);
    check(d == ref_mem[12'h122], "R6 current read after page write", d, ref_mem[12'h122]);
    rand_read(12'h120, d); check(d == 8'hA2, "R5 wrapped byte 0", d, 8'hA2);
    rand_read(12'h121, d); check(d == 8'hA3, "R5 wrapped byte 1", d, 8'hA3);
    rand_read(12'h13F, d); check(d == 8'hA1, "R5 last byte of page", d, 8'hA1);
    rand_read(12'h140, d); check(d == ref_mem[12'h140], "R5 next page untouched", d, ref_mem[12'h140]);

    // R8: sequential read across the top of the array
    set_addr(12'hFFE);
    bus_start();
    put_byte(SEL_RD, ak); check(ak, "R8 read select ack", ak, 1);
    for (int k = 0; k < 4; k++) begin
      int ea;
      ea = (12'hFFE + k) & 12'hFFF;
      get_byte(d, k != 3);
      check(d == ref_mem[ea], "R8 sequential byte (R10 MSB first)", d, ref_mem[ea]);
    end
    bus_stop();

    // R9: after NACK the engine stays released while clocks continue
    bus_start();
    put_byte(SEL_RD, ak); check(ak, "R9 read select ack", ak, 1);
    get_byte(d, 1'b0);
    check(d == ref_mem[2], "R9 byte before nack", d, ref_mem[2]);
    get_byte(d, 1'b0);
    check(d == 8'hFF, "R9 bus released after nack", d, 8'hFF);
    bus_stop();
    cur_read(d);
    check(d == ref_mem[3], "R9 pointer one past last sent", d, ref_mem[3]);

    // R1: a STOP in the middle of an address phase, then a fresh START works
    bus_start();
    put_byte(SEL_WR, ak); check(ak, "R1 select before stop", ak, 1);
    bus_stop();
    check(sda_oe == 1'b0, "R1 released after stop", sda_oe, 0);
    rand_read(12'h7FF, d);
    check(d == ref_mem[12'h7FF], "R1 new transfer after stop", d, ref_mem[12'h7FF]);

    check(bad_oe == 0, "R10 output moved while SCL high", bad_oe, 0);
    check(we_long == 0, "R11 write strobe wider than one cycle", we_long, 0);
    done = 1'b1;
    finish_run();
  end
endmodule